// File: doc/BRIEF.md
# GPIO Level/Pulse Output Controller

This block drives a port of general-purpose output pins from a small register interface with an address and data strobe. Each pin runs in one of two ways. In level drive the pin follows its data bit. In one-shot drive, writing a 1 to the data bit raises the pin for a timed interval, after which the pin and the data bit fall by themselves.

All pins share one two-bit duration selector, which picks one of four fixed widths. Every pin has its own down-counter, and each counter is stepped by a shared tick. A prescaler derives that tick from the system clock by dividing `CLK_HZ` by `TICK_HZ`. With the default 1 MHz tick, the four widths are 500 us, 1 ms, 20 ms and 100 ms. A read-only status register returns the live pin levels.

Top module: `gpo_pulse_ctrl`

## Requirements
- R1: A synchronous reset clears the data, mode and width registers, the timers and the read data. After reset every pin is low and in level mode, and the width code is 00.
- R2: The register map is: data at 11h, status at 12h, mode at 13h (bit n is 1 for one-shot drive on pin n and 0 for level drive), and width at 14h. A read returns its value on `rd_data` at the clock edge that samples `rd_en`, taken from the register state before that edge. The value then holds until the next read. A read of any other address returns 0.
- R3: The width register keeps only bits [1:0]. Bits [7:2] always read back as 0, whatever was written to them.
- R4: For a pin in level drive, a write to the data register sets the pin to the written bit from the next clock edge onward.
- R5: For a pin in one-shot drive, writing a 1 raises the pin and its data bit at the next edge. Both fall at the edge of the N-th tick after the triggering edge. N is W0, W1, W2 or W3 for width codes 00, 01, 10 and 11 (500, 1000, 20000 and 100000 by default). A tick occurs every CLK_HZ/TICK_HZ clocks, counted from reset.
- R6: For a pin in one-shot drive, writing a 0 has no effect on the pin or on a running pulse.
- R7: A running pulse keeps the width that was selected when it was triggered. A later write to the width register changes only pulses triggered after it.
- R8: Writing a 1 to a pin whose pulse is already running restarts that pin's full width, counted from the new write.
- R9: Changing a pin's mode bit in either direction clears that pin's data bit and stops its timer at once. A pulse that is running therefore ends, and the pin is low until the next data write.
- R10: Reading the status register returns the pin levels, with bit n taken from pin n.
- R11: Writes to the status address or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Register index |
| wr_data | input | NPINS | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NPINS | Registered read data |
| pin_out | output | NPINS | Output pins |

## Verification
The bench triggers a pulse and then writes a 0 to the same pin. A design that treats the 0 as a stop would drop the pin early. It retriggers a running pulse and measures the new length. A design that ignores the retrigger would end the pulse roughly when the first trigger was due. It also changes the width selector in the middle of a pulse. A design that reads the live selector would stretch that pulse to the longest width.

The bench also flips a mode bit while a pulse is running, which must leave the pin low at once. It writes all ones to the width register, the status address and an unmapped address. A design that keeps the reserved bits, or that decodes the address loosely, shows it in the readback.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

   typedef enum logic [1:0] {
      WSEL_SHORT = 2'b00,
      WSEL_MED   = 2'b01,
      WSEL_LONG  = 2'b10,
      WSEL_MAX   = 2'b11
   } wsel_e;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/gpo_tick_gen.sv
module gpo_tick_gen #(
   parameter int unsigned DIV = 50
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_every
         logic run_q;
         always_ff @(posedge clk) begin
            if (rst) run_q <= 1'b0;
            else     run_q <= 1'b1;
         end
         assign tick = run_q;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] pre_q;
         assign tick = (pre_q == PW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (rst)       pre_q <= '0;
            else if (tick) pre_q <= '0;
            else           pre_q <= pre_q + 1'b1;
         end

         assert_pre_range_R5: assert property (@(posedge clk) disable iff (rst)
            !tick |=> pre_q == $past(pre_q) + 1'b1);
      end
   endgenerate

endmodule

// File: rtl/gpo_pin_timer.sv
module gpo_pin_timer #(
   parameter int unsigned CW = 17
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          load,
   input  logic          cancel,
   input  logic [CW-1:0] load_val,
   output logic          busy,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   assign busy   = (cnt_q != '0);
   assign expire = tick && (cnt_q == CW'(1)) && !load && !cancel;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cancel)       cnt_q <= '0;
      else if (tick && busy) cnt_q <= cnt_q - 1'b1;
   end

   assert_load_width_R8: assert property (@(posedge clk) disable iff (rst)
      load |=> cnt_q == $past(load_val));

   assert_cancel_stop_R9: assert property (@(posedge clk) disable iff (rst)
      (cancel && !load) |=> !busy);

   assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
      (!tick && !load && !cancel) |=> $stable(cnt_q));

endmodule

// File: rtl/gpo_pulse_ctrl.sv
module gpo_pulse_ctrl
   import gpo_pkg::*;
#(
   parameter int unsigned   NPINS   = 8,
   parameter int unsigned   AW      = 8,
   parameter int unsigned   CLK_HZ  = 50_000_000,
   parameter int unsigned   TICK_HZ = 1_000_000,
   parameter int unsigned   W0      = 500,
   parameter int unsigned   W1      = 1000,
   parameter int unsigned   W2      = 20000,
   parameter int unsigned   W3      = 100000,
   parameter logic [AW-1:0] A_DATA  = AW'('h11),
   parameter logic [AW-1:0] A_STAT  = AW'('h12),
   parameter logic [AW-1:0] A_MODE  = AW'('h13),
   parameter logic [AW-1:0] A_WIDTH = AW'('h14)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    addr,
   input  logic [NPINS-1:0] wr_data,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic [NPINS-1:0] rd_data,
   output logic [NPINS-1:0] pin_out
);

   localparam int unsigned DIV  = CLK_HZ / TICK_HZ;
   localparam int unsigned WMAX = max4(W0, W1, W2, W3);
   localparam int unsigned CW   = $clog2(WMAX + 1);

   generate
      if (NPINS < 2) begin : g_bad_pins
         $error("NPINS must be at least 2 to hold the width code");
      end
      if (TICK_HZ == 0 || CLK_HZ < TICK_HZ || (CLK_HZ % TICK_HZ) != 0) begin : g_bad_div
         $error("CLK_HZ must be a nonzero multiple of TICK_HZ");
      end
      if (W0 == 0 || W1 == 0 || W2 == 0 || W3 == 0) begin : g_bad_width
         $error("every pulse width must be at least one tick");
      end
   endgenerate

   logic [NPINS-1:0] data_q, data_d, mode_q, done;
   wsel_e            wsel_q;
   logic [CW-1:0]    width_ticks;
   logic             tick;
   logic             wr_dat, wr_mode, wr_wid;

   assign wr_dat  = wr_en && (addr == A_DATA);
   assign wr_mode = wr_en && (addr == A_MODE);
   assign wr_wid  = wr_en && (addr == A_WIDTH);

   gpo_tick_gen #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   always_comb begin
      unique case (wsel_q)
         WSEL_SHORT: width_ticks = CW'(W0);
         WSEL_MED:   width_ticks = CW'(W1);
         WSEL_LONG:  width_ticks = CW'(W2);
         default:    width_ticks = CW'(W3);
      endcase
   end

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         logic flip, trig, lvl_wr, busy;

         assign flip   = wr_mode && (wr_data[p] != mode_q[p]);
         assign trig   = wr_dat && mode_q[p] && wr_data[p];
         assign lvl_wr = wr_dat && !mode_q[p];

         gpo_pin_timer #(.CW(CW)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .load     (trig),
            .cancel   (flip),
            .load_val (width_ticks),
            .busy     (busy),
            .expire   (done[p])
         );

         always_comb begin
            if (flip)         data_d[p] = 1'b0;
            else if (lvl_wr)  data_d[p] = wr_data[p];
            else if (trig)    data_d[p] = 1'b1;
            else if (done[p]) data_d[p] = 1'b0;
            else              data_d[p] = data_q[p];
         end

         assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
            lvl_wr |=> pin_out[p] == $past(wr_data[p]));

         assert_rise_by_write_R5: assert property (@(posedge clk) disable iff (rst)
            (mode_q[p] && $rose(pin_out[p])) |-> $past(wr_dat && wr_data[p]));

         assert_zero_ignored_R6: assert property (@(posedge clk) disable iff (rst)
            (wr_dat && mode_q[p] && !wr_data[p] && !done[p]) |=> $stable(pin_out[p]));

         assert_flip_clears_R9: assert property (@(posedge clk) disable iff (rst)
            ($rose(mode_q[p]) || $fell(mode_q[p])) |-> !pin_out[p] && !busy);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
         mode_q <= '0;
         wsel_q <= WSEL_SHORT;
      end else begin
         data_q <= data_d;
         if (wr_mode) mode_q <= wr_data;
         if (wr_wid)  wsel_q <= wsel_e'(wr_data[1:0]);
      end
   end

   assign pin_out = data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (addr == A_DATA)       rd_data <= data_q;
         else if (addr == A_STAT)  rd_data <= pin_out;
         else if (addr == A_MODE)  rd_data <= mode_q;
         else if (addr == A_WIDTH) rd_data <= {{(NPINS-2){1'b0}}, wsel_q};
         else                      rd_data <= '0;
      end
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pin_out == '0) && (mode_q == '0) && (rd_data == '0));

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == A_WIDTH) |=> rd_data[NPINS-1:2] == '0);

   assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

endmodule

// File: tb/gpo_pulse_ctrl_tb.sv
`timescale 1ns/1ps
module gpo_pulse_ctrl_tb;

   localparam int DIV = 3;
   localparam int W0 = 4, W1 = 6, W2 = 9, W3 = 13;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data, pin_out;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   gpo_pulse_ctrl #(
      .NPINS(8), .AW(8), .CLK_HZ(DIV), .TICK_HZ(1),
      .W0(W0), .W1(W1), .W2(W2), .W3(W3)
   ) u_dut (
      .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
      .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out)
   );

   // behavioural reference model
   logic [7:0] m_data, m_mode, m_rd, nd;
   int         m_rem [8];
   int         m_wsel, m_presc;
   bit         tk;

   function automatic int width_of(int code);
      case (code)
         0: return W0;
         1: return W1;
         2: return W2;
         default: return W3;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_data = '0; m_mode = '0; m_rd = '0; m_wsel = 0; m_presc = 0;
         for (int i = 0; i < 8; i++) m_rem[i] = 0;
      end else begin
         tk = (m_presc == DIV - 1);
         if (rd_en) begin
            case (addr)
               8'h11, 8'h12: m_rd = m_data;
               8'h13:        m_rd = m_mode;
               8'h14:        m_rd = 8'(m_wsel);
               default:      m_rd = '0;
            endcase
         end
         nd = m_data;
         for (int i = 0; i < 8; i++) begin
            if (wr_en && addr == 8'h13 && wr_data[i] != m_mode[i]) begin
               nd[i] = 1'b0; m_rem[i] = 0;
            end else if (wr_en && addr == 8'h11 && !m_mode[i]) begin
               nd[i] = wr_data[i];
            end else if (wr_en && addr == 8'h11 && wr_data[i]) begin
               nd[i] = 1'b1; m_rem[i] = width_of(m_wsel);
            end else if (tk && m_rem[i] > 0) begin
               m_rem[i]--;
               if (m_rem[i] == 0) nd[i] = 1'b0;
            end
         end
         m_data = nd;
         if (wr_en && addr == 8'h13) m_mode = wr_data;
         if (wr_en && addr == 8'h14) m_wsel = int'(wr_data[1:0]);
         m_presc = tk ? 0 : m_presc + 1;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done_flag) begin
         chk(pin_out == m_data, "R5 pins vs model", pin_out, m_data);
         chk(rd_data == m_rd,   "R2 read data vs model", rd_data, m_rd);
      end
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic measure(int pin, output int len);
      len = 0;
      while (pin_out[pin]) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [7:0] v;
      int len;
      idle(3);
      rst = 1'b0;

      // R1 reset state
      chk(pin_out == 8'h00, "R1 pins after reset", pin_out, 0);
      rd(8'h11, v); chk(v == 8'h00, "R1 data after reset", v, 0);
      rd(8'h13, v); chk(v == 8'h00, "R1 mode after reset", v, 0);
      rd(8'h14, v); chk(v == 8'h00, "R1 width after reset", v, 0);
      rd(8'h20, v); chk(v == 8'h00, "R2 unmapped read", v, 0);

      // R3 reserved bits
      wr(8'h14, 8'hFF);
      rd(8'h14, v); chk(v == 8'h03, "R3 width readback", v, 8'h03);
      wr(8'h14, 8'h00);

      // R4 level drive, R10 status
      wr(8'h11, 8'hA5);
      chk(pin_out == 8'hA5, "R4 level pins", pin_out, 8'hA5);
      rd(8'h12, v); chk(v == 8'hA5, "R10 status readback", v, 8'hA5);
      wr(8'h11, 8'h3C);
      chk(pin_out == 8'h3C, "R4 level pins second", pin_out, 8'h3C);

      // R9 mode change clears data
      wr(8'h13, 8'h0F);
      chk(pin_out == 8'h30, "R9 mode entry clears", pin_out, 8'h30);
      rd(8'h13, v); chk(v == 8'h0F, "R2 mode readback", v, 8'h0F);

      // R5 pulse at code 00
      wr(8'h11, 8'h31);
      measure(0, len);
      chk(len >= (W0-1)*DIV+1 && len <= W0*DIV, "R5 pulse length code 00", len, W0*DIV);
      rd(8'h11, v); chk(v == 8'h30, "R5 data bit cleared", v, 8'h30);

      // R6 zero write ignored
      wr(8'h11, 8'h32);
      wr(8'h11, 8'h30);
      chk(pin_out[1] == 1'b1, "R6 zero write ignored", pin_out[1], 1);
      measure(1, len);

      // R7 width captured at trigger
      wr(8'h11, 8'h34);
      wr(8'h14, 8'h03);
      measure(2, len);
      chk(len <= W0*DIV, "R7 running width kept", len, W0*DIV);
      wr(8'h11, 8'h38);
      measure(3, len);
      chk(len >= (W3-1)*DIV+1 && len <= W3*DIV, "R5 pulse length code 11", len, W3*DIV);

      // R8 retrigger restarts
      wr(8'h11, 8'h31);
      idle(20);
      wr(8'h11, 8'h31);
      measure(0, len);
      chk(len >= (W3-1)*DIV+1 && len <= W3*DIV, "R8 retrigger length", len, W3*DIV);

      // R9 cancel on mode change, then level follow
      wr(8'h11, 8'h32);
      idle(5);
      wr(8'h13, 8'h0D);
      chk(pin_out[1] == 1'b0, "R9 cancel running pulse", pin_out[1], 0);
      wr(8'h11, 8'h32);
      chk(pin_out[1] == 1'b1, "R9 level after cancel", pin_out[1], 1);

      // R11 ignored writes
      wr(8'h12, 8'hFF);
      wr(8'h40, 8'hFF);
      rd(8'h13, v); chk(v == 8'h0D, "R11 mode untouched", v, 8'h0D);
      rd(8'h14, v); chk(v == 8'h03, "R11 width untouched", v, 8'h03);
      rd(8'h11, v); chk(v == 8'h32, "R11 data untouched", v, 8'h32);
      chk(pin_out == 8'h32, "R11 pins untouched", pin_out, 8'h32);

      idle(2);
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule